// File: doc/BRIEF.md
# Five-Level Phase-Leg Gate Pattern Generator

This block produces the five gate commands for one leg of a five-level single-phase inverter. The leg has one auxiliary switch, which puts half of the bus voltage on the output, and a four-switch H-bridge. Every clock cycle the block takes a signed sample of the sinusoidal reference and the current value of a triangular carrier counter. From the magnitude of the reference it chooses one of two stacked comparison bands, and from that band it selects an output level: zero, half or full, with the sign of the reference. It then maps the level onto the five gates.

The auxiliary switch and the two upper-rate bridge switches toggle at the carrier rate. The two polarity switches follow only the sign of the reference, so they change at line frequency. A band controller has three states. `BAND_OFF` holds after reset until the first nonzero reference arrives. `BAND_INNER` compares the reference magnitude itself against the carrier. `BAND_OUTER` compares the part of the magnitude above the carrier peak against the carrier. Five transitions connect them:
- off-to-inner: a nonzero reference at or below the peak.
- off-to-outer and inner-to-outer: a magnitude above the peak.
- outer-to-inner: a zero crossing, meaning a zero reference or a sign change, with the new magnitude at or below the peak.
- outer-to-outer: the band is kept.

Top module: `fivelvl_gate_gen`

## Requirements
- R1: A synchronous active-high reset drives all five gates to 0 on the next edge and enters `BAND_OFF`. While the reference stays at 0 after reset, the gates stay 0.
- R2: Gate bit i drives switch i+1: bit 0 is the auxiliary switch, bits 1 and 2 are the fast bridge switches, bits 3 and 4 are the polarity switches. The codes are: positive half = 5'b10001, positive full = 5'b10010, negative half = 5'b01001, negative full = 5'b01100, positive zero = 5'b10000, negative zero = 5'b01000.
- R3: In the inner band (|ref| not above CAR_PEAK) the level is half when |ref| is strictly greater than the carrier, and zero otherwise, including when the two are equal.
- R4: A magnitude above CAR_PEAK enters the outer band in the same cycle. There the level is full when |ref| − CAR_PEAK is strictly greater than the carrier, and half otherwise.
- R5: The outer band persists while the reference keeps a nonzero value of the same sign, even after |ref| falls to CAR_PEAK or below. In that case the excess counts as 0, so the level is half whatever the carrier is.
- R6: A zero reference or a change of sign leaves the outer band. The band is then chosen again from the new magnitude.
- R7: A positive reference turns on bit 4 and a negative reference turns on bit 3. The two bits are never 1 together.
- R8: A zero reference outputs the zero level and keeps the polarity bits of the last nonzero reference.
- R9: The gates are registered. They reflect the inputs sampled at a clock edge right after that edge and do not change before it.
- R10: At most one of bits 0 to 2 is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ref_i | input | REF_W | Signed reference sample |
| car_i | input | CAR_W | Triangular carrier counter, 0 to CAR_PEAK |
| gate_o | output | 5 | Gate commands, bit i drives switch i+1 |

## Verification
The assertions assume that the carrier never exceeds CAR_PEAK. They also assume the reference moves through zero or through a sign change only in ways the band controller can observe from one sample to the next. The polarity-hold check further assumes that a zero sample really means the reference is parked at zero. The stimulus keeps the carrier between 0 and CAR_PEAK and presents each reference value for a whole clock cycle. It reaches the outer band only by magnitudes just above the peak, and it reaches sign changes both through zero and directly from the outer band.

// File: rtl/fivelvl_pkg.sv
package fivelvl_pkg;

    typedef enum logic [1:0] {
        BAND_OFF   = 2'd0,
        BAND_INNER = 2'd1,
        BAND_OUTER = 2'd2
    } band_t;

    typedef enum logic [1:0] {
        LVL_ZERO = 2'd0,
        LVL_HALF = 2'd1,
        LVL_FULL = 2'd2
    } level_t;

    localparam int GATE_N   = 5;
    localparam int G_AUX    = 0;
    localparam int G_FAST_P = 1;
    localparam int G_FAST_N = 2;
    localparam int G_LEG_N  = 3;
    localparam int G_LEG_P  = 4;

endpackage

// File: rtl/fivelvl_ref_front.sv
module fivelvl_ref_front #(
    parameter int REF_W = 16
) (
    input  logic signed [REF_W-1:0] ref_i,
    output logic        [REF_W-1:0] mag_o,
    output logic                    zero_o,
    output logic                    neg_o
);

    always_comb begin
        neg_o  = ref_i[REF_W-1];
        zero_o = (ref_i == '0);
        if (neg_o) begin
            mag_o = (~ref_i) + REF_W'(1);
        end else begin
            mag_o = ref_i;
        end
    end

endmodule

// File: rtl/fivelvl_band_fsm.sv
module fivelvl_band_fsm
    import fivelvl_pkg::*;
#(
    parameter int MAG_W    = 16,
    parameter int CAR_PEAK = 2000
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [MAG_W-1:0] mag_i,
    input  logic             zero_i,
    input  logic             neg_i,
    output band_t            band_q,
    output band_t            band_nxt,
    output logic             pol_neg_q,
    output logic             pol_neg_nxt
);

    localparam logic [MAG_W-1:0] PEAK_M = MAG_W'(CAR_PEAK);

    logic over_peak;
    logic crossing;

    assign over_peak = (mag_i > PEAK_M);
    assign crossing  = zero_i || (neg_i != pol_neg_q);

    always_comb begin
        band_nxt = band_q;
        unique case (band_q)
            BAND_OFF: begin
                if (!zero_i) begin
                    band_nxt = over_peak ? BAND_OUTER : BAND_INNER;
                end
            end
            BAND_INNER: begin
                band_nxt = over_peak ? BAND_OUTER : BAND_INNER;
            end
            BAND_OUTER: begin
                if (crossing) begin
                    band_nxt = over_peak ? BAND_OUTER : BAND_INNER;
                end
            end
            default: band_nxt = BAND_OFF;
        endcase
        pol_neg_nxt = zero_i ? pol_neg_q : neg_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            band_q    <= BAND_OFF;
            pol_neg_q <= 1'b0;
        end else begin
            band_q    <= band_nxt;
            pol_neg_q <= pol_neg_nxt;
        end
    end

    // R5: outer band kept while the sign holds and the reference is nonzero
    p_outer_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (band_q == BAND_OUTER && !zero_i && neg_i == pol_neg_q) |=> band_q == BAND_OUTER);

    // R1: the block stays off until a nonzero reference appears
    p_off_wait_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (band_q == BAND_OFF && zero_i) |=> band_q == BAND_OFF);

    // R6: a zero reference never leaves the block in the outer band
    p_zero_exit_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (band_q == BAND_OUTER && zero_i) |=> band_q == BAND_INNER);

endmodule

// File: rtl/fivelvl_level_sel.sv
module fivelvl_level_sel
    import fivelvl_pkg::*;
#(
    parameter int MAG_W    = 16,
    parameter int CAR_W    = 12,
    parameter int CAR_PEAK = 2000
) (
    input  band_t            band_i,
    input  logic [MAG_W-1:0] mag_i,
    input  logic [CAR_W-1:0] car_i,
    output level_t           level_o
);

    localparam logic [MAG_W-1:0] PEAK_M = MAG_W'(CAR_PEAK);

    logic [MAG_W-1:0] car_ext;
    logic [MAG_W-1:0] excess;

    generate
        if (CAR_W < MAG_W) begin : g_pad
            assign car_ext = {{(MAG_W-CAR_W){1'b0}}, car_i};
        end else begin : g_cut
            assign car_ext = car_i[MAG_W-1:0];
        end
    endgenerate

    assign excess = (mag_i > PEAK_M) ? (mag_i - PEAK_M) : '0;

    always_comb begin
        level_o = LVL_ZERO;
        unique case (band_i)
            BAND_OFF:   level_o = LVL_ZERO;
            BAND_INNER: level_o = (mag_i > car_ext) ? LVL_HALF : LVL_ZERO;
            BAND_OUTER: level_o = (excess > car_ext) ? LVL_FULL : LVL_HALF;
            default:    level_o = LVL_ZERO;
        endcase
    end

endmodule

// File: rtl/fivelvl_gate_map.sv
module fivelvl_gate_map
    import fivelvl_pkg::*;
(
    input  band_t             band_i,
    input  level_t            level_i,
    input  logic              neg_i,
    output logic [GATE_N-1:0] gate_o
);

    always_comb begin
        gate_o = '0;
        if (band_i != BAND_OFF) begin
            if (neg_i) begin
                gate_o[G_LEG_N] = 1'b1;
            end else begin
                gate_o[G_LEG_P] = 1'b1;
            end
            unique case (level_i)
                LVL_ZERO: ;
                LVL_HALF: gate_o[G_AUX] = 1'b1;
                LVL_FULL: begin
                    if (neg_i) begin
                        gate_o[G_FAST_N] = 1'b1;
                    end else begin
                        gate_o[G_FAST_P] = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fivelvl_gate_gen.sv
module fivelvl_gate_gen
    import fivelvl_pkg::*;
#(
    parameter int REF_W    = 16,
    parameter int CAR_W    = 12,
    parameter int CAR_PEAK = 2000
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic signed [REF_W-1:0] ref_i,
    input  logic        [CAR_W-1:0] car_i,
    output logic        [4:0]       gate_o
);

    localparam int MAG_W = REF_W;

    logic [MAG_W-1:0]  mag;
    logic              ref_zero;
    logic              ref_neg;
    band_t             band_q;
    band_t             band_nxt;
    logic              pol_neg_q;
    logic              pol_neg_nxt;
    level_t            level;
    logic [GATE_N-1:0] gate_nxt;
    logic [GATE_N-1:0] gate_q;

    fivelvl_ref_front #(.REF_W(REF_W)) u_front (
        .ref_i  (ref_i),
        .mag_o  (mag),
        .zero_o (ref_zero),
        .neg_o  (ref_neg)
    );

    fivelvl_band_fsm #(.MAG_W(MAG_W), .CAR_PEAK(CAR_PEAK)) u_fsm (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .mag_i       (mag),
        .zero_i      (ref_zero),
        .neg_i       (ref_neg),
        .band_q      (band_q),
        .band_nxt    (band_nxt),
        .pol_neg_q   (pol_neg_q),
        .pol_neg_nxt (pol_neg_nxt)
    );

    fivelvl_level_sel #(.MAG_W(MAG_W), .CAR_W(CAR_W), .CAR_PEAK(CAR_PEAK)) u_level (
        .band_i  (band_nxt),
        .mag_i   (mag),
        .car_i   (car_i),
        .level_o (level)
    );

    fivelvl_gate_map u_map (
        .band_i  (band_nxt),
        .level_i (level),
        .neg_i   (pol_neg_nxt),
        .gate_o  (gate_nxt)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_nxt;
        end
    end

    assign gate_o = gate_q;

    // R1: reset clears every gate on the next edge
    p_reset_clear_r1: assert property (@(posedge clk_i)
        rst_i |=> gate_o == '0);

    // R7: the two polarity switches are never on together
    p_legs_exclusive_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !(gate_o[G_LEG_N] && gate_o[G_LEG_P]));

    // R10: at most one carrier-rate switch is on
    p_fast_onehot_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(gate_o[2:0]));

    // R4: a full level only appears in the outer band
    p_full_outer_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (gate_o[G_FAST_P] || gate_o[G_FAST_N]) |-> band_q == BAND_OUTER);

    // R8: a zero reference keeps the polarity switches where they were
    p_leg_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (ref_zero && band_q != BAND_OFF) |=> $stable(gate_o[4:3]));

    // R7: polarity switch follows the sign of a nonzero reference
    p_leg_sign_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!ref_zero && !ref_neg) |=> gate_o[G_LEG_P]);

endmodule

// File: tb/sim_fivelvl_gate_gen.sv
module sim_fivelvl_gate_gen;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic signed [15:0] ref_s = '0;
    logic [11:0]        car = '0;
    logic [4:0]         gate;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    localparam logic [4:0] P_HALF = 5'b10001;
    localparam logic [4:0] P_FULL = 5'b10010;
    localparam logic [4:0] N_HALF = 5'b01001;
    localparam logic [4:0] N_FULL = 5'b01100;
    localparam logic [4:0] P_ZERO = 5'b10000;
    localparam logic [4:0] N_ZERO = 5'b01000;

    always #2 clk = ~clk;

    fivelvl_gate_gen #(.REF_W(16), .CAR_W(12), .CAR_PEAK(2000)) u0 (
        .clk_i  (clk),
        .rst_i  (rst),
        .ref_i  (ref_s),
        .car_i  (car),
        .gate_o (gate)
    );

    task automatic check(input string req, input logic [4:0] exp);
        n_checks++;
        if (gate !== exp) begin
            n_errors++;
            $display("FAIL %s: gate=%b expected=%b", req, gate, exp);
        end
        n_checks++;
        if (gate[3] && gate[4]) begin
            n_errors++;
            $display("FAIL R7: gate=%b expected legs exclusive", gate);
        end
        n_checks++;
        if ($countones(gate[2:0]) > 1) begin
            n_errors++;
            $display("FAIL R10: gate=%b expected at most one fast switch", gate);
        end
    endtask

    // called at a negedge; inputs held through one posedge, sampled at next negedge
    task automatic step(input int r, input int c);
        ref_s = 16'(r);
        car   = 12'(c);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(0, 0);
        step(0, 0);
        check("R1 reset", 5'b00000);
        rst = 1'b0;
        step(0, 0);
        check("R1 zero ref after reset", 5'b00000);
        step(0, 700);
        check("R1 still off", 5'b00000);
    endtask

    task automatic t_inner_pos();
        step(1000, 500);
        check("R3 R2 positive half", P_HALF);
        step(1000, 1500);
        check("R3 R2 positive zero", P_ZERO);
        step(1000, 1000);
        check("R3 equal gives zero", P_ZERO);
        step(2000, 1999);
        check("R3 peak stays inner", P_HALF);
    endtask

    task automatic t_outer_pos();
        step(2500, 300);
        check("R4 R2 positive full", P_FULL);
        step(2500, 700);
        check("R4 outer half", P_HALF);
        step(2500, 500);
        check("R4 excess equal gives half", P_HALF);
        step(1500, 1800);
        check("R5 outer hold half", P_HALF);
    endtask

    task automatic t_exit_zero();
        step(0, 0);
        check("R6 R8 zero exits outer", P_ZERO);
        step(1500, 1800);
        check("R6 back to inner", P_ZERO);
    endtask

    task automatic t_negative();
        step(-1000, 500);
        check("R7 R2 negative half", N_HALF);
        step(-2600, 100);
        check("R4 R2 negative full", N_FULL);
        step(-1000, 1800);
        check("R5 negative outer hold", N_HALF);
        step(0, 100);
        check("R8 negative zero holds leg", N_ZERO);
        step(-500, 900);
        check("R3 negative inner zero", N_ZERO);
    endtask

    task automatic t_sign_flip();
        step(-2600, 100);
        check("R4 negative full before flip", N_FULL);
        step(1500, 1800);
        check("R6 R7 sign flip exits outer", P_ZERO);
    endtask

    task automatic t_latency();
        step(0, 0);
        check("R9 setup zero", P_ZERO);
        @(posedge clk);
        #1;
        ref_s = 16'(1000);
        car   = 12'(500);
        #1;
        check("R9 no change before edge", P_ZERO);
        @(posedge clk);
        #1;
        check("R9 change after edge", P_HALF);
        @(negedge clk);
    endtask

    task automatic t_reset_mid();
        step(2500, 100);
        check("R4 full before reset", P_FULL);
        rst = 1'b1;
        step(2500, 100);
        check("R1 reset mid run", 5'b00000);
        rst = 1'b0;
        step(0, 0);
        check("R1 off after reset", 5'b00000);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_inner_pos();
        t_outer_pos();
        t_exit_zero();
        t_negative();
        t_sign_flip();
        t_latency();
        t_reset_mid();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule